// File: doc/BRIEF.md
# Instruction Address Breakpoint Unit

This block watches the stream of instruction addresses that a core is about to execute. It compares each one with two breakpoint registers that software programs. When an enabled register matches a valid address while debug is globally enabled, the block raises a breakpoint request in the same cycle. The core can then take a debug exception before that instruction executes. The block also records an entry-reason code of 3'b001, which debug software reads to learn why the core stopped.

Each breakpoint register is one 32-bit word. Bit 0 turns the register on, and bits 31:1 hold the target address. The compare width follows the instruction-set mode. With 32-bit instructions, the address is matched on word granularity and register bit 1 is not used. With 16-bit instructions, the address is matched on half-word granularity. The stored address is used exactly as written. Any process-ID adjustment must be applied by software before the write. Software reaches the two breakpoint words and the entry-reason register through a small indexed register port.

Top module: `ibkpt_unit`

## Requirements
- R1: After reset, both breakpoint enable bits read 0, the entry reason is 3'b000, and no hit is reported.
- R2: A write with index 0 or 1 stores the full 32-bit `reg_wdata` into that breakpoint register. Reading that index through the combinational `reg_rdata` returns the stored word.
- R3: In word mode (`isa_half`=0), a register matches when address bits 31:2 equal register bits 31:2. Address bits 1:0 and register bit 1 are not compared.
- R4: In half-word mode (`isa_half`=1), a register matches when address bits 31:1 equal register bits 31:1. Address bit 0 is not compared.
- R5: A register whose bit 0 is 0 never causes a hit.
- R6: `bp_hit` is 0 whenever `iaddr_vld` is 0 or `dbg_en` is 0.
- R7: `bp_hit` is combinational. It is asserted in the same cycle as the matching address and equals the OR of both per-register matches, so a match on both registers yields one hit.
- R8: In the cycle after a hit, `entry_reason` is 3'b001.
- R9: Index 2 is the entry-reason register. Writing it loads `reg_wdata[2:0]` on the next edge, and reading it returns the reason zero-extended to 32 bits. A hit in the same cycle takes priority over the write. With neither a hit nor a write, the reason holds its value.
- R10: A breakpoint write takes effect for addresses presented from the next cycle on. A compare in the same cycle as the write uses the old value.
- R11: Index 3 is reserved. It reads as zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register index: 0,1 breakpoints, 2 entry reason, 3 reserved |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the register chosen by `reg_sel` |
| iaddr | input | 32 | Instruction address under test |
| iaddr_vld | input | 1 | `iaddr` is valid this cycle |
| isa_half | input | 1 | 1 = 16-bit instruction mode, 0 = 32-bit instruction mode |
| dbg_en | input | 1 | Global debug enable |
| bp_hit | output | 1 | Breakpoint request for the current address |
| entry_reason | output | 3 | Recorded debug entry reason |

## Verification
Random addresses are drawn close to the programmed targets by flipping only bits 0 and 1. These separate word matching from half-word matching: an address differing only in bit 1 must hit in word mode and miss in half-word mode. Other addresses are placed far from the targets to confirm misses. The random stream also toggles the enable bits, `iaddr_vld` and `dbg_en`, so each qualifier is tried on its own. Writes to the entry-reason register in the same cycle as a hit show the priority rule. Directed cases cover compares that fall in the same cycle as a breakpoint write, hits on both registers at once, and writes to the reserved index.

// File: rtl/ibkpt_pkg.sv
package ibkpt_pkg;
  localparam int unsigned REASON_W = 3;
  localparam logic [REASON_W-1:0] REASON_NONE  = 3'b000;
  localparam logic [REASON_W-1:0] REASON_IBKPT = 3'b001;
endpackage

// File: rtl/ibkpt_bank.sv
module ibkpt_bank #(
  parameter int unsigned AW     = 32,
  parameter int unsigned NUM_BP = 2,
  parameter int unsigned SEL_W  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [SEL_W-1:0]           sel,
  input  logic [AW-1:0]              wdata,
  output logic [NUM_BP-1:0][AW-1:0]  bp_word
);
  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    logic          we;
    logic          en_q, en_d;
    logic [AW-1:1] adr_q, adr_d;

    assign we = wr && (sel == SEL_W'(i));

    always_comb begin
      en_d  = we ? wdata[0]    : en_q;
      adr_d = we ? wdata[AW-1:1] : adr_q;
    end

    // enable bit is reset; address bits carry no reset
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= en_d;
    end

    always_ff @(posedge clk) begin
      adr_q <= adr_d;
    end

    assign bp_word[i] = {adr_q, en_q};
  end
endmodule

// File: rtl/ibkpt_match.sv
module ibkpt_match #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] bp_word,
  input  logic          half,
  output logic          match
);
  logic [AW-1:0] cmp_mask;

  always_comb begin
    cmp_mask       = '1;
    cmp_mask[1]    = half;
    cmp_mask[0]    = 1'b0;
    match = bp_word[0] && (((addr ^ bp_word) & cmp_mask) == '0);
  end
endmodule

// File: rtl/ibkpt_reason.sv
module ibkpt_reason
  import ibkpt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hit,
  input  logic                sw_we,
  input  logic [REASON_W-1:0] sw_data,
  output logic [REASON_W-1:0] reason_q
);
  logic                reason_ce;
  logic [REASON_W-1:0] reason_d;

  always_comb begin
    reason_ce = hit || sw_we;
    reason_d  = hit ? REASON_IBKPT : sw_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reason_q <= REASON_NONE;
    else if (reason_ce) reason_q <= reason_d;
  end
endmodule

// File: rtl/ibkpt_unit.sv
module ibkpt_unit
  import ibkpt_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned NUM_BP = 2,
  parameter int unsigned SEL_W  = $clog2(NUM_BP + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [SEL_W-1:0]    reg_sel,
  input  logic [AW-1:0]       reg_wdata,
  output logic [AW-1:0]       reg_rdata,
  input  logic [AW-1:0]       iaddr,
  input  logic                iaddr_vld,
  input  logic                isa_half,
  input  logic                dbg_en,
  output logic                bp_hit,
  output logic [REASON_W-1:0] entry_reason
);
  localparam logic [SEL_W-1:0] REASON_IDX = SEL_W'(NUM_BP);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  logic [NUM_BP-1:0][AW-1:0] bp_word;
  logic [NUM_BP-1:0]         bp_match;
  logic [NUM_BP-1:0]         bp_en;

  ibkpt_bank #(.AW(AW), .NUM_BP(NUM_BP), .SEL_W(SEL_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_ok),
    .wr      (reg_wr),
    .sel     (reg_sel),
    .wdata   (reg_wdata),
    .bp_word (bp_word)
  );

  for (genvar i = 0; i < NUM_BP; i++) begin : g_cmp
    assign bp_en[i] = bp_word[i][0];
    ibkpt_match #(.AW(AW)) u_match (
      .addr    (iaddr),
      .bp_word (bp_word[i]),
      .half    (isa_half),
      .match   (bp_match[i])
    );
  end

  assign bp_hit = iaddr_vld && dbg_en && (|bp_match);

  ibkpt_reason u_reason (
    .clk      (clk),
    .rst_n    (rst_ok),
    .hit      (bp_hit),
    .sw_we    (reg_wr && (reg_sel == REASON_IDX)),
    .sw_data  (reg_wdata[REASON_W-1:0]),
    .reason_q (entry_reason)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_sel == REASON_IDX) begin
      reg_rdata[REASON_W-1:0] = entry_reason;
    end else begin
      for (int i = 0; i < NUM_BP; i++) begin
        if (reg_sel == SEL_W'(i)) reg_rdata = bp_word[i];
      end
    end
  end
endmodule

// File: rtl/ibkpt_unit_chk.sv
module ibkpt_unit_chk
  import ibkpt_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned NUM_BP = 2,
  parameter int unsigned SEL_W  = 2
) (
  input logic                clk,
  input logic                rst_ok,
  input logic                reg_wr,
  input logic [SEL_W-1:0]    reg_sel,
  input logic [AW-1:0]       reg_wdata,
  input logic                iaddr_vld,
  input logic                dbg_en,
  input logic [NUM_BP-1:0]   bp_en,
  input logic                bp_hit,
  input logic [REASON_W-1:0] entry_reason
);
  localparam logic [SEL_W-1:0] RIDX = SEL_W'(NUM_BP);

  p_gated_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (!iaddr_vld || !dbg_en) |-> !bp_hit);

  p_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    bp_hit |-> (bp_en != '0));

  p_reason_on_hit_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    bp_hit |=> (entry_reason == REASON_IBKPT));

  p_reason_hold_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    (!bp_hit && !(reg_wr && reg_sel == RIDX)) |=> $stable(entry_reason));

  p_reason_write_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    (!bp_hit && reg_wr && reg_sel == RIDX) |=>
      (entry_reason == $past(reg_wdata[REASON_W-1:0])));
endmodule

bind ibkpt_unit ibkpt_unit_chk #(.AW(AW), .NUM_BP(NUM_BP), .SEL_W(SEL_W)) u_chk (
  .clk          (clk),
  .rst_ok       (rst_ok),
  .reg_wr       (reg_wr),
  .reg_sel      (reg_sel),
  .reg_wdata    (reg_wdata),
  .iaddr_vld    (iaddr_vld),
  .dbg_en       (dbg_en),
  .bp_en        (bp_en),
  .bp_hit       (bp_hit),
  .entry_reason (entry_reason)
);

// File: tb/ibkpt_unit_test.sv
`timescale 1ns/1ps
module ibkpt_unit_test;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [31:0] iaddr;
  logic        iaddr_vld;
  logic        isa_half;
  logic        dbg_en;
  logic        bp_hit;
  logic [2:0]  entry_reason;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [31:0] m_bp [2];
  logic [2:0]  m_reason;

  ibkpt_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .iaddr(iaddr),
    .iaddr_vld(iaddr_vld), .isa_half(isa_half), .dbg_en(dbg_en),
    .bp_hit(bp_hit), .entry_reason(entry_reason)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic reg_match(logic [31:0] a, logic [31:0] r, logic half);
    if (!r[0]) return 1'b0;
    if (half) return a[31:1] == r[31:1];
    return a[31:2] == r[31:2];
  endfunction

  function automatic logic exp_hit();
    return iaddr_vld && dbg_en &&
           (reg_match(iaddr, m_bp[0], isa_half) || reg_match(iaddr, m_bp[1], isa_half));
  endfunction

  function automatic logic [31:0] exp_rdata();
    case (reg_sel)
      2'd0: return m_bp[0];
      2'd1: return m_bp[1];
      2'd2: return {29'd0, m_reason};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // inputs already set after a negedge; check combinational results, then clock and update model
  task automatic step(string req);
    logic h;
    #2;
    h = exp_hit();
    check({req, " hit"}, {31'd0, bp_hit}, {31'd0, h});
    check("R2/R9/R11 rdata", reg_rdata, exp_rdata());
    check("R8/R9 reason", {29'd0, entry_reason}, {29'd0, m_reason});
    @(posedge clk);
    if (h) m_reason = 3'b001;
    else if (reg_wr && reg_sel == 2'd2) m_reason = reg_wdata[2:0];
    if (reg_wr && reg_sel < 2'd2) m_bp[reg_sel] = reg_wdata;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wr_reg(logic [1:0] s, logic [31:0] d);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d; iaddr_vld = 1'b0;
    step("R2");
  endtask

  task automatic probe(logic [31:0] a, logic half, string req);
    iaddr = a; iaddr_vld = 1'b1; isa_half = half; reg_sel = 2'd2;
    step(req);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1b7e_5a03));
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 2'd0; reg_wdata = '0;
    iaddr = '0; iaddr_vld = 1'b0; isa_half = 1'b0; dbg_en = 1'b1;
    m_reason = 3'b000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    reg_sel = 2'd0; #1 check("R1 en0", {31'd0, reg_rdata[0]}, 32'd0);
    reg_sel = 2'd1; #1 check("R1 en1", {31'd0, reg_rdata[0]}, 32'd0);
    check("R1 reason", {29'd0, entry_reason}, 32'd0);
    iaddr_vld = 1'b1; iaddr = 32'h0; #1 check("R1 hit", {31'd0, bp_hit}, 32'd0);
    iaddr_vld = 1'b0;
    m_bp[0] = {reg_rdata[31:1], 1'b0};
    reg_sel = 2'd0; #1 m_bp[0] = reg_rdata;
    reg_sel = 2'd1; #1 m_bp[1] = reg_rdata;
    @(negedge clk);

    // directed
    wr_reg(2'd0, 32'h0000_1003);              // enabled, bit1 set
    wr_reg(2'd1, 32'h8000_0000);              // disabled
    probe(32'h0000_1000, 1'b0, "R3 bit1 ignored word");
    wr_reg(2'd2, 32'h0000_0005);
    probe(32'h0000_1000, 1'b1, "R4 bit1 compared half");
    probe(32'h0000_1002, 1'b1, "R4 half match");
    probe(32'h0000_1003, 1'b1, "R4 bit0 ignored half");
    probe(32'h8000_0000, 1'b0, "R5 disabled reg");
    dbg_en = 1'b0;
    probe(32'h0000_1000, 1'b0, "R6 dbg off");
    dbg_en = 1'b1;
    iaddr = 32'h0000_1000; iaddr_vld = 1'b0; step("R6 vld off");
    wr_reg(2'd1, 32'h0000_1001);              // both match 0x1000 in word mode
    probe(32'h0000_1000, 1'b0, "R7 both match");
    // R10: write in same cycle as compare uses old value
    reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 32'h0000_2001;
    wr_reg(2'd1, 32'h0);
    reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 32'h0000_2001;
    iaddr = 32'h0000_2000; iaddr_vld = 1'b1; isa_half = 1'b0;
    step("R10 same-cycle old value");
    probe(32'h0000_2000, 1'b0, "R10 next cycle new value");
    // R9 priority: reason write with concurrent hit
    reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = 32'h6;
    iaddr = 32'h0000_2000; iaddr_vld = 1'b1;
    step("R9 hit priority");
    wr_reg(2'd2, 32'h7);
    // R11 reserved index
    wr_reg(2'd3, 32'hFFFF_FFFF);
    reg_sel = 2'd3; iaddr_vld = 1'b0; step("R11 reserved");
    reg_sel = 2'd0; step("R11 bp0 untouched");

    // random
    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 9);
      logic [31:0] base = m_bp[$urandom_range(0, 1)];
      if (op == 0) begin
        reg_wr = 1'b1; reg_sel = 2'($urandom_range(0, 1));
        reg_wdata = {$urandom_range(0, 15) == 0 ? $urandom() : {24'h000031, 8'($urandom())}};
      end else if (op == 1) begin
        reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = $urandom();
      end else if (op == 2) begin
        reg_wr = 1'b1; reg_sel = 2'd3; reg_wdata = $urandom();
      end else begin
        reg_sel = 2'($urandom_range(0, 3));
      end
      iaddr = (op == 9) ? $urandom() : (base ^ 32'($urandom_range(0, 3)));
      iaddr_vld = ($urandom_range(0, 7) != 0);
      dbg_en = ($urandom_range(0, 7) != 0);
      isa_half = 1'($urandom_range(0, 1));
      step("R3/R4/R5/R6/R7 random");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule